// File: doc/BRIEF.md
# External Bus Gateway (Wishbone Host)

This block connects a processor-side single-request bus to a 32-bit Wishbone B4 host port. A request is one cycle of `req_i` with its address, write data, byte enables and direction. The gateway holds the access on the external bus until the target acknowledges it, reports an error, or an optional cycle timeout expires. It then returns one response to the processor side: either an acknowledge with read data, or an error.

Parameters set the behaviour at build time. `PIPE_MODE` selects a classic or a pipelined handshake. `BIG_ENDIAN` selects big-endian byte order across the gateway. `TX_BYPASS` and `RX_BYPASS` remove the outgoing and the incoming register stage. `TIMEOUT` sets a cycle limit on each access, and 0 turns the limit off. When both register stages are kept, each access costs two extra cycles, and the outgoing lines hold their values between transfers. Each stage that is bypassed removes one cycle.

Top module: `ext_bus_gateway`

## Requirements
- R1: After reset, `wb_cyc_o`, `wb_stb_o`, `wb_we_o`, `rsp_ack_o` and `rsp_err_o` are 0, and `wb_adr_o`, `wb_dat_o` and `wb_sel_o` are all zero.
- R2: A request is accepted when `req_i` is high and no access is open. With the transmit register kept, the address, data, byte select, write enable, cycle and strobe appear on the external port in the cycle after acceptance. With `TX_BYPASS`=1 they appear in the acceptance cycle itself.
- R3: In classic mode (`PIPE_MODE`=0), `wb_stb_o` equals `wb_cyc_o` in every cycle.
- R4: In pipelined mode (`PIPE_MODE`=1), `wb_stb_o` is high only in the first cycle of an access. `wb_cyc_o` stays high until the access ends.
- R5: When `wb_ack_i` is high while `wb_cyc_o` is high, the access ends and `rsp_ack_o` pulses for one cycle with `wb_dat_i` on `rsp_data_o`. This response comes one cycle after the acknowledge when the receive register is kept, and in the same cycle when `RX_BYPASS`=1. `wb_cyc_o` and `wb_stb_o` are low in the cycle after the terminating input.
- R6: When `wb_err_i` is high while `wb_cyc_o` is high, the access ends with `rsp_err_o` high and `rsp_ack_o` low. Error wins when `wb_err_i` and `wb_ack_i` are high together.
- R7: With `TIMEOUT`=N>0, an access with no acknowledge or error during its first N cycles of `wb_cyc_o` ends with an error response, due at the same latency as R6. With `TIMEOUT`=0, an access stays open for as long as it is unanswered.
- R8: With `BIG_ENDIAN`=1, byte lane k (bits 8k+7:8k) of the write data goes to lane 3-k of `wb_dat_o`, and lane k of `wb_dat_i` goes to lane 3-k of `rsp_data_o`. `be_i` bit k drives `wb_sel_o` bit 3-k.
- R9: With the transmit register kept, `wb_adr_o`, `wb_dat_o`, `wb_sel_o` and `wb_we_o` change only in the cycle after a request is accepted. They keep their values while idle and after an access ends.
- R10: A request that arrives while an access is open is dropped. It changes no external output and starts no later access.
- R11: `rsp_data_o` is zero in every cycle where `rsp_ack_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables |
| rsp_data_o | output | 32 | Read data, zero unless acknowledged |
| rsp_ack_o | output | 1 | Access completed |
| rsp_err_o | output | 1 | Access failed (bus error or timeout) |
| wb_adr_o | output | ADDR_W | External address |
| wb_dat_i | input | 32 | External read data |
| wb_dat_o | output | 32 | External write data |
| wb_we_o | output | 1 | External write enable |
| wb_sel_o | output | 4 | External byte select |
| wb_stb_o | output | 1 | External strobe |
| wb_cyc_o | output | 1 | External cycle valid |
| wb_ack_i | input | 1 | External acknowledge |
| wb_err_i | input | 1 | External error |

## Verification
With both register stages kept, the external lines are sampled at the falling edge after the edge that accepts the request. The response is sampled at the falling edge after the edge that sees the acknowledge or error. In the timeout case, the error is expected exactly N falling edges after the first cycle in which `wb_cyc_o` is seen high. A second instance uses both bypass paths, pipelined mode and big-endian order. Its external lines are checked shortly after the inputs change in the request cycle, and its response shortly after the acknowledge is driven, because no register lies on either path.

// File: rtl/gw_pkg.sv
package gw_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;

  typedef logic [DW-1:0] word_t;
  typedef logic [NB-1:0] sel_t;

  function automatic word_t swap_word(input word_t w);
    word_t r;
    for (int k = 0; k < NB; k++) r[8*k +: 8] = w[8*(NB-1-k) +: 8];
    return r;
  endfunction

  function automatic sel_t mirror_sel(input sel_t s);
    sel_t r;
    for (int k = 0; k < NB; k++) r[k] = s[NB-1-k];
    return r;
  endfunction
endpackage

// File: rtl/gw_ctrl.sv
module gw_ctrl #(
  parameter bit PIPE_MODE = 1'b0,
  parameter bit TX_BYPASS = 1'b0,
  parameter int TIMEOUT   = 255
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ack_i,
  input  logic err_i,
  output logic accept_o,
  output logic busy_o,
  output logic cyc_o,
  output logic stb_o,
  output logic term_ack_o,
  output logic term_err_o
);
  localparam int CNT_W = (TIMEOUT > 0) ? $clog2(TIMEOUT + 1) : 1;

  logic busy_q;
  logic tmo;
  logic term;

  assign accept_o = req_i & ~busy_q;
  assign busy_o   = busy_q;

  generate
    if (TX_BYPASS) begin : g_cyc_live
      assign cyc_o = busy_q | accept_o;
    end else begin : g_cyc_reg
      assign cyc_o = busy_q;
    end
  endgenerate

  generate
    if (!PIPE_MODE) begin : g_stb_classic
      assign stb_o = cyc_o;
      p_stb_eq_cyc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_o |-> stb_o);
    end else if (TX_BYPASS) begin : g_stb_pipe_live
      assign stb_o = accept_o;
    end else begin : g_stb_pipe_reg
      logic stb_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stb_q <= 1'b0;
        else         stb_q <= accept_o;
      end
      assign stb_o = stb_q;
      p_stb_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_o |=> !stb_o);
    end
  endgenerate

  generate
    if (TIMEOUT > 0) begin : g_tmo
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       cnt_q <= '0;
        else if (accept_o) cnt_q <= '0;
        else if (busy_q)   cnt_q <= cnt_q + 1'b1;
      end
      assign tmo = busy_q && (cnt_q == CNT_W'(TIMEOUT - 1));
      p_tmo_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_q |-> (int'(cnt_q) < TIMEOUT));
    end else begin : g_no_tmo
      assign tmo = 1'b0;
    end
  endgenerate

  assign term_err_o = cyc_o & (err_i | tmo);
  assign term_ack_o = cyc_o & ack_i & ~term_err_o;
  assign term       = term_err_o | term_ack_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= 1'b0;
    else if (busy_q) busy_q <= ~term;
    else             busy_q <= accept_o & ~term;
  end

  p_stb_in_cyc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> cyc_o);
  p_drop_after_term_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o && (ack_i || err_i)) |=> !busy_q);
endmodule

// File: rtl/gw_tx_path.sv
module gw_tx_path
  import gw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter bit BIG_ENDIAN = 1'b0,
  parameter bit TX_BYPASS  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wdata_i,
  input  sel_t              be_i,
  input  logic              we_i,
  output logic [ADDR_W-1:0] adr_o,
  output word_t             dat_o,
  output sel_t              sel_o,
  output logic              we_o
);
  word_t             wd_lane;
  sel_t              be_lane;
  logic [ADDR_W-1:0] adr_q;
  word_t             dat_q;
  sel_t              sel_q;
  logic              we_q;

  generate
    if (BIG_ENDIAN) begin : g_big
      assign wd_lane = swap_word(wdata_i);
      assign be_lane = mirror_sel(be_i);
    end else begin : g_little
      assign wd_lane = wdata_i;
      assign be_lane = be_i;
    end
  endgenerate

  // capture only on accept: lines stay quiet between transfers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adr_q <= '0;
      dat_q <= '0;
      sel_q <= '0;
      we_q  <= 1'b0;
    end else if (accept_i) begin
      adr_q <= addr_i;
      dat_q <= wd_lane;
      sel_q <= be_lane;
      we_q  <= we_i;
    end
  end

  generate
    if (TX_BYPASS) begin : g_live
      assign adr_o = busy_i ? adr_q : addr_i;
      assign dat_o = busy_i ? dat_q : wd_lane;
      assign sel_o = busy_i ? sel_q : be_lane;
      assign we_o  = busy_i ? we_q  : we_i;
    end else begin : g_reg
      assign adr_o = adr_q;
      assign dat_o = dat_q;
      assign sel_o = sel_q;
      assign we_o  = we_q;
      p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i || !accept_i) |=> ($stable(adr_o) && $stable(dat_o)
                                   && $stable(sel_o) && $stable(we_o)));
    end
  endgenerate
endmodule

// File: rtl/gw_rx_path.sv
module gw_rx_path
  import gw_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0,
  parameter bit RX_BYPASS  = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  term_ack_i,
  input  logic  term_err_i,
  input  word_t dat_i,
  output logic  ack_o,
  output logic  err_o,
  output word_t data_o
);
  word_t lane;
  word_t data_raw;

  generate
    if (BIG_ENDIAN) begin : g_big
      assign lane = swap_word(dat_i);
    end else begin : g_little
      assign lane = dat_i;
    end
  endgenerate

  assign data_raw = term_ack_i ? lane : '0;

  generate
    if (RX_BYPASS) begin : g_live
      assign ack_o  = term_ack_i;
      assign err_o  = term_err_i;
      assign data_o = data_raw;
    end else begin : g_reg
      logic  ack_q;
      logic  err_q;
      word_t data_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ack_q  <= 1'b0;
          err_q  <= 1'b0;
          data_q <= '0;
        end else begin
          ack_q  <= term_ack_i;
          err_q  <= term_err_i;
          data_q <= data_raw;
        end
      end
      assign ack_o  = ack_q;
      assign err_o  = err_q;
      assign data_o = data_q;
    end
  endgenerate

  p_rdata_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> (data_o == '0));
  p_err_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !ack_o);
endmodule

// File: rtl/ext_bus_gateway.sv
module ext_bus_gateway
  import gw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int TIMEOUT    = 255,
  parameter bit PIPE_MODE  = 1'b0,
  parameter bit BIG_ENDIAN = 1'b0,
  parameter bit RX_BYPASS  = 1'b0,
  parameter bit TX_BYPASS  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        be_i,
  output logic [31:0]       rsp_data_o,
  output logic              rsp_ack_o,
  output logic              rsp_err_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_we_o,
  output logic [3:0]        wb_sel_o,
  output logic              wb_stb_o,
  output logic              wb_cyc_o,
  input  logic              wb_ack_i,
  input  logic              wb_err_i
);
  logic accept;
  logic busy;
  logic term_ack;
  logic term_err;

  gw_ctrl #(
    .PIPE_MODE (PIPE_MODE),
    .TX_BYPASS (TX_BYPASS),
    .TIMEOUT   (TIMEOUT)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .ack_i      (wb_ack_i),
    .err_i      (wb_err_i),
    .accept_o   (accept),
    .busy_o     (busy),
    .cyc_o      (wb_cyc_o),
    .stb_o      (wb_stb_o),
    .term_ack_o (term_ack),
    .term_err_o (term_err)
  );

  gw_tx_path #(
    .ADDR_W     (ADDR_W),
    .BIG_ENDIAN (BIG_ENDIAN),
    .TX_BYPASS  (TX_BYPASS)
  ) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .busy_i   (busy),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .be_i     (be_i),
    .we_i     (we_i),
    .adr_o    (wb_adr_o),
    .dat_o    (wb_dat_o),
    .sel_o    (wb_sel_o),
    .we_o     (wb_we_o)
  );

  gw_rx_path #(
    .BIG_ENDIAN (BIG_ENDIAN),
    .RX_BYPASS  (RX_BYPASS)
  ) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .term_ack_i (term_ack),
    .term_err_i (term_err),
    .dat_i      (wb_dat_i),
    .ack_o      (rsp_ack_o),
    .err_o      (rsp_err_o),
    .data_o     (rsp_data_o)
  );

  p_resp_needs_cyc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_ack_o || rsp_err_o) |-> (RX_BYPASS ? wb_cyc_o : !busy));
endmodule

// File: tb/ext_bus_gateway_tb.sv
module ext_bus_gateway_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO_A      = 8;

  typedef struct packed {
    logic        we;
    logic [31:0] adr;
    logic [31:0] wd;
    logic [3:0]  be;
    logic [31:0] rd;
    logic [3:0]  wt;
    logic        er;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 32'h1000_0000, 32'hDEAD_BEEF, 4'hF, 32'h0000_0000, 4'd0, 1'b0},
    '{1'b0, 32'h2000_0004, 32'h0000_0000, 4'hF, 32'h1234_5678, 4'd2, 1'b0},
    '{1'b1, 32'h3000_0008, 32'h0000_00A5, 4'h1, 32'h0000_0000, 4'd3, 1'b0},
    '{1'b0, 32'h0000_0010, 32'h0000_0000, 4'hC, 32'hCAFE_F00D, 4'd1, 1'b0},
    '{1'b1, 32'hF000_0000, 32'h55AA_55AA, 4'h6, 32'h0000_0000, 4'd0, 1'b1},
    '{1'b0, 32'h4000_0020, 32'h0000_0000, 4'hF, 32'h0BAD_F00D, 4'd5, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // instance A: defaults, registered both ways, classic, little endian
  logic        req, we, cyc, stb, wwe, ack, err, r_ack, r_err;
  logic [31:0] adr, wd, rd, r_data, wadr, wdo;
  logic [3:0]  be, sel;

  ext_bus_gateway #(.TIMEOUT(TMO_A)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(adr),
    .wdata_i(wd), .be_i(be), .rsp_data_o(r_data), .rsp_ack_o(r_ack),
    .rsp_err_o(r_err), .wb_adr_o(wadr), .wb_dat_i(rd), .wb_dat_o(wdo),
    .wb_we_o(wwe), .wb_sel_o(sel), .wb_stb_o(stb), .wb_cyc_o(cyc),
    .wb_ack_i(ack), .wb_err_i(err)
  );

  // instance B: both stages bypassed, pipelined, big endian, no timeout
  logic        b_req, b_we, b_cyc, b_stb, b_wwe, b_ack, b_err, b_r_ack, b_r_err;
  logic [31:0] b_adr, b_wd, b_rd, b_r_data, b_wadr, b_wdo;
  logic [3:0]  b_be, b_sel;

  ext_bus_gateway #(.TIMEOUT(0), .PIPE_MODE(1'b1), .BIG_ENDIAN(1'b1),
                    .RX_BYPASS(1'b1), .TX_BYPASS(1'b1)) u_dut_b (
    .clk_i(clk), .rst_ni(rst_n), .req_i(b_req), .we_i(b_we), .addr_i(b_adr),
    .wdata_i(b_wd), .be_i(b_be), .rsp_data_o(b_r_data), .rsp_ack_o(b_r_ack),
    .rsp_err_o(b_r_err), .wb_adr_o(b_wadr), .wb_dat_i(b_rd), .wb_dat_o(b_wdo),
    .wb_we_o(b_wwe), .wb_sel_o(b_sel), .wb_stb_o(b_stb), .wb_cyc_o(b_cyc),
    .wb_ack_i(b_ack), .wb_err_i(b_err)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // issue request on A and return at the negedge where cyc should be up
  task automatic start_a(input logic w, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] b);
    req = 1'b1; we = w; adr = a; wd = d; be = b;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    start_a(v.we, v.adr, v.wd, v.be);
    chk("R2 cyc up", {31'd0, cyc}, 32'd1);
    chk("R2 adr", wadr, v.adr);
    chk("R2 we", {31'd0, wwe}, {31'd0, v.we});
    if (v.we) begin
      chk("R2 dat_o", wdo, v.wd);
      chk("R2 sel", {28'd0, sel}, {28'd0, v.be});
    end
    for (int i = 0; i < int'(v.wt); i++) @(negedge clk);
    chk("R3 stb follows cyc", {30'd0, cyc, stb}, 32'd3);
    ack = ~v.er; err = v.er; rd = v.rd;
    @(negedge clk);
    chk(v.er ? "R6 err rsp" : "R5 ack rsp", {30'd0, r_ack, r_err},
        v.er ? 32'd1 : 32'd2);
    chk("R5 data", r_data, v.er ? 32'd0 : v.rd);
    chk("R5 cyc dropped", {30'd0, cyc, stb}, 32'd0);
    ack = 1'b0; err = 1'b0; rd = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R11 data zero idle", r_data, 32'd0);
    chk("R9 adr held", wadr, v.adr);
  endtask

  initial begin
    int cyc_cnt = 0;
    while (!done) begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 20000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc_cnt);
        summary();
        $finish;
      end
    end
  end

  initial begin
    req = 0; we = 0; adr = 0; wd = 0; be = 0; rd = 0; ack = 0; err = 0;
    b_req = 0; b_we = 0; b_adr = 0; b_wd = 0; b_be = 0; b_rd = 0; b_ack = 0; b_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctl", {27'd0, cyc, stb, wwe, r_ack, r_err}, 32'd0);
    chk("R1 adr", wadr, 32'd0);
    chk("R1 dat", wdo, 32'd0);
    chk("R1 sel", {28'd0, sel}, 32'd0);

    for (int i = 0; i < 6; i++) run_vec(VEC[i]);

    // R6: error dominates a simultaneous ack
    start_a(1'b0, 32'h0000_0100, 32'd0, 4'hF);
    ack = 1'b1; err = 1'b1; rd = 32'h1111_2222;
    @(negedge clk);
    chk("R6 err over ack", {30'd0, r_ack, r_err}, 32'd1);
    ack = 1'b0; err = 1'b0;
    @(negedge clk);

    // R10: request during an open access is dropped
    start_a(1'b0, 32'h0000_0040, 32'd0, 4'hF);
    req = 1'b1; adr = 32'h0000_0080; we = 1'b1; wd = 32'h7777_7777;
    @(negedge clk);
    req = 1'b0;
    chk("R10 adr unchanged", wadr, 32'h0000_0040);
    chk("R10 we unchanged", {31'd0, wwe}, 32'd0);
    ack = 1'b1; rd = 32'h0000_00AB;
    @(negedge clk);
    chk("R5 ack after drop", r_data, 32'h0000_00AB);
    ack = 1'b0;
    @(negedge clk);
    chk("R10 no later access", {31'd0, cyc}, 32'd0);

    // R7: timeout after TMO_A cycles of cyc
    start_a(1'b0, 32'h0000_0200, 32'd0, 4'hF);
    for (int i = 0; i < TMO_A - 1; i++) @(negedge clk);
    chk("R7 still open", {29'd0, cyc, r_ack, r_err}, 32'd4);
    @(negedge clk);
    chk("R7 timeout err", {29'd0, cyc, r_ack, r_err}, 32'd1);
    @(negedge clk);

    // instance B: bypass, pipelined, big endian, no timeout
    b_req = 1'b1; b_we = 1'b1; b_adr = 32'h0000_0100; b_wd = 32'h1122_3344; b_be = 4'b0011;
    #1;
    chk("R2 bypass cyc/stb", {30'd0, b_cyc, b_stb}, 32'd3);
    chk("R2 bypass adr", b_wadr, 32'h0000_0100);
    chk("R8 wdata swap", b_wdo, 32'h4433_2211);
    chk("R8 sel mirror", {28'd0, b_sel}, 32'h0000_000C);
    @(negedge clk);
    b_req = 1'b0; b_wd = 32'h0; b_be = 4'h0;
    #1;
    chk("R4 stb single", {30'd0, b_cyc, b_stb}, 32'd2);
    chk("R8 wdata held", b_wdo, 32'h4433_2211);
    repeat (20) @(negedge clk);
    chk("R7 disabled", {29'd0, b_cyc, b_r_ack, b_r_err}, 32'd4);
    b_ack = 1'b1; b_rd = 32'hAABB_CCDD;
    #1;
    chk("R5 same-cycle ack", {30'd0, b_r_ack, b_r_err}, 32'd2);
    chk("R8 rdata swap", b_r_data, 32'hDDCC_BBAA);
    @(negedge clk);
    b_ack = 1'b0;
    #1;
    chk("R5 bypass cyc dropped", {31'd0, b_cyc}, 32'd0);
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule